// File: doc/BRIEF.md
# Selectable Ring / Twisted-Ring Sequence Generator

This block is a clocked chain of flip-flop stages whose feedback into the first stage is picked at run time. In ring mode the last stage feeds stage 0 directly, so a single high bit travels around the chain and the generator steps through as many states as it has stages. In twisted-ring (Johnson) mode the complement of the last stage feeds stage 0, which doubles the number of states. Each state differs from the one before it in a single stage.

Every state of the active mode has its own decoded strobe, so downstream control logic can use one wire per step of a timing sequence without decoding it again. In ring mode the stage outputs are the strobes. In twisted-ring mode each strobe is a two-input AND of stage outputs or their complements. A synchronous initialise, a change of mode and any pattern that does not belong to the active mode all load the starting pattern of that mode.

Top module: `twist_ring_gen`

## Requirements
- R1: With `mode` = 0 (ring), a clock edge with `rst` high loads stage 0 with 1 and every other stage with 0.
- R2: With `mode` = 1 (twisted ring), a clock edge with `rst` high clears every stage to 0.
- R3: In ring mode, each enabled edge moves stage i into stage i+1 and the last stage into stage 0, so the pattern repeats every STAGES enabled edges.
- R4: In twisted-ring mode, each enabled edge moves stage i into stage i+1 and loads stage 0 with the complement of the last stage. Exactly one stage changes per step, and the pattern repeats every 2*STAGES enabled edges.
- R5: With `en` low and `mode` unchanged, the stages hold their values.
- R6: The first clock edge after `mode` differs from the mode of the current pattern loads the starting pattern of the new mode (R1/R2), whatever the value of `en`.
- R7: In ring mode, `strobe[i]` equals `stage_q[i]` for i < STAGES, and `strobe[STAGES..2*STAGES-1]` is 0.
- R8: In twisted-ring mode, exactly one strobe is high: `strobe[k]`, where k counts the steps from the all-zero pattern. k is the number of ones when stage 0 is 1 or all stages are 0, and 2*STAGES minus the number of ones otherwise.
- R9: The stage pattern is always legal for its mode: exactly one 1 in ring mode, or at most one boundary between adjacent unequal stages in twisted-ring mode. Any other pattern is replaced by the starting pattern on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high initialise |
| en | input | 1 | Step enable |
| mode | input | 1 | Feedback select: 0 ring, 1 twisted ring |
| stage_q | output | STAGES | Stage outputs, bit i is stage i |
| strobe | output | 2*STAGES | One decoded strobe per state |

## Verification
The bench goes after the wrap points: ring mode returning to stage 0, and twisted ring going from all ones to a cleared stage 0 and from the last single one back to all zeros. A design with the wrong feedback polarity would lock up, or drift into a pattern with two runs. It also changes the mode on enabled and disabled cycles alike. A design that kept shifting the old pattern would then show two ones in ring mode or a broken run in twisted-ring mode. Strobes are compared with an index computed from the count of ones, so a single swapped AND term shows up as the wrong strobe or as two strobes at once.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

    typedef enum logic {
        SEQ_RING  = 1'b0,
        SEQ_TWIST = 1'b1
    } seq_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_INIT  = 2'd2
    } seq_act_e;

    function automatic seq_act_e pick_action(
        input logic      rst,
        input logic      en,
        input seq_mode_e req_mode,
        input seq_mode_e cur_mode,
        input logic      legal
    );
        if (rst || req_mode != cur_mode || !legal) return ACT_INIT;
        if (en) return ACT_SHIFT;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/seq_legal.sv
module seq_legal
    import seqgen_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] pat,
    input  seq_mode_e         cur_mode,
    output logic              legal
);
    localparam int EDGES = STAGES - 1;

    logic [EDGES-1:0] boundary;

    generate
        for (genvar i = 0; i < EDGES; i++) begin : g_bnd
            assign boundary[i] = pat[i] ^ pat[i+1];
        end
    endgenerate

    always_comb begin
        if (cur_mode == SEQ_RING) legal = ($countones(pat) == 1);
        else                      legal = ($countones(boundary) <= 1);
    end

endmodule

// File: rtl/seq_shift.sv
module seq_shift
    import seqgen_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  seq_mode_e         req_mode,
    input  seq_act_e          act,
    output logic [STAGES-1:0] q,
    output seq_mode_e         cur_mode,
    output logic              primed
);
    localparam logic [STAGES-1:0] RING_SEED  = {{(STAGES-1){1'b0}}, 1'b1};
    localparam logic [STAGES-1:0] TWIST_SEED = '0;

    logic [STAGES-1:0] fed;

    always_comb begin
        fed = {q[STAGES-2:0], q[STAGES-1]};
        if (cur_mode == SEQ_TWIST) fed[0] = ~q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b1;
        unique case (act)
            ACT_INIT: begin
                q        <= (req_mode == SEQ_RING) ? RING_SEED : TWIST_SEED;
                cur_mode <= req_mode;
            end
            ACT_SHIFT: q <= fed;
            default:   q <= q;
        endcase
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (primed && !en && req_mode == cur_mode) |=> $stable(q));

    assert_one_step_R4: assert property (@(posedge clk) disable iff (rst)
        (primed && en && req_mode == cur_mode && cur_mode == SEQ_TWIST)
        |=> $countones(q ^ $past(q)) == 1);

    assert_mode_seed_R6: assert property (@(posedge clk) disable iff (rst)
        (primed && req_mode != cur_mode)
        |=> q == ((cur_mode == SEQ_RING) ? RING_SEED : TWIST_SEED));

    assert_ring_move_R3: assert property (@(posedge clk) disable iff (rst)
        (primed && en && req_mode == cur_mode && cur_mode == SEQ_RING)
        |=> q == {$past(q[STAGES-2:0]), $past(q[STAGES-1])});

endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seqgen_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0]   q,
    input  seq_mode_e           cur_mode,
    input  logic                primed,
    input  logic                clk,
    input  logic                rst,
    output logic [2*STAGES-1:0] strobe
);
    localparam int NSTATE = 2 * STAGES;

    logic [NSTATE-1:0] ring_s;
    logic [NSTATE-1:0] twist_s;

    generate
        for (genvar k = 0; k < NSTATE; k++) begin : g_state
            if (k < STAGES) begin : g_ring_on
                assign ring_s[k] = q[k];
            end else begin : g_ring_off
                assign ring_s[k] = 1'b0;
            end

            if (k == 0) begin : g_zero
                assign twist_s[k] = ~q[0] & ~q[STAGES-1];
            end else if (k < STAGES) begin : g_fill
                assign twist_s[k] = q[k-1] & ~q[k];
            end else if (k == STAGES) begin : g_full
                assign twist_s[k] = q[0] & q[STAGES-1];
            end else begin : g_drain
                assign twist_s[k] = ~q[k-STAGES-1] & q[k-STAGES];
            end
        end
    endgenerate

    assign strobe = (cur_mode == SEQ_TWIST) ? twist_s : ring_s;

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        primed |-> $onehot(strobe));

    assert_ring_upper_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (primed && cur_mode == SEQ_RING) |-> strobe[NSTATE-1:STAGES] == '0);

endmodule

// File: rtl/twist_ring_gen.sv
module twist_ring_gen
    import seqgen_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                mode,
    output logic [STAGES-1:0]   stage_q,
    output logic [2*STAGES-1:0] strobe
);
    seq_mode_e req_mode;
    seq_mode_e cur_mode;
    seq_act_e  act;
    logic      legal;
    logic      primed;

    assign req_mode = seq_mode_e'(mode);

    seq_legal #(.STAGES(STAGES)) u_legal (
        .pat      (stage_q),
        .cur_mode (cur_mode),
        .legal    (legal)
    );

    assign act = pick_action(rst, en, req_mode, cur_mode, legal);

    seq_shift #(.STAGES(STAGES)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .req_mode (req_mode),
        .act      (act),
        .q        (stage_q),
        .cur_mode (cur_mode),
        .primed   (primed)
    );

    seq_decode #(.STAGES(STAGES)) u_decode (
        .q        (stage_q),
        .cur_mode (cur_mode),
        .primed   (primed),
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe)
    );

    assert_pattern_legal_R9: assert property (@(posedge clk) disable iff (rst)
        primed |-> legal);

    assert_ring_seed_R1: assert property (@(posedge clk) disable iff (1'b0)
        (rst && mode == 1'b0) |=> stage_q == {{(STAGES-1){1'b0}}, 1'b1});

    assert_twist_seed_R2: assert property (@(posedge clk) disable iff (1'b0)
        (rst && mode == 1'b1) |=> stage_q == '0);

endmodule

// File: tb/sim_twist_ring_gen.sv
module sim_twist_ring_gen;
    localparam int N       = 4;
    localparam int CLK_PER = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           en  = 1'b0;
    logic           mode = 1'b0;
    logic [N-1:0]   stage_q;
    logic [2*N-1:0] strobe;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] exp_q;
    logic         exp_mode;
    string        exp_tag;
    logic         have_exp = 1'b0;

    twist_ring_gen #(.STAGES(N)) u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .stage_q(stage_q), .strobe(strobe)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [N-1:0] seed_of(input logic m);
        return m ? '0 : {{(N-1){1'b0}}, 1'b1};
    endfunction

    function automatic logic [N-1:0] advance(input logic [N-1:0] p, input logic m);
        logic [N-1:0] r;
        for (int i = N-1; i > 0; i--) r[i] = p[i-1];
        r[0] = m ? ~p[N-1] : p[N-1];
        return r;
    endfunction

    function automatic logic [2*N-1:0] strobe_of(input logic [N-1:0] p, input logic m);
        int ones = 0;
        int idx;
        for (int i = 0; i < N; i++) ones += int'(p[i]);
        if (!m) return {{N{1'b0}}, p};
        idx = (p[0] || ones == 0) ? ones : 2*N - ones;
        return (2*N)'(1) << idx;
    endfunction

    function automatic bit is_legal(input logic [N-1:0] p, input logic m);
        int cnt = 0;
        if (!m) begin
            for (int i = 0; i < N; i++) cnt += int'(p[i]);
            return cnt == 1;
        end
        for (int i = 0; i < N-1; i++) cnt += int'(p[i] != p[i+1]);
        return cnt <= 1;
    endfunction

    task automatic check_now();
        logic [2*N-1:0] es;
        checks++;
        if (stage_q !== exp_q) begin
            errors++;
            $display("FAIL %s stage_q actual %b expected %b", exp_tag, stage_q, exp_q);
        end
        es = strobe_of(exp_q, exp_mode);
        checks++;
        if (strobe !== es) begin
            errors++;
            $display("FAIL %s strobe actual %b expected %b",
                     exp_mode ? "R8" : "R7", strobe, es);
        end
        checks++;
        if (!is_legal(stage_q, exp_mode)) begin
            errors++;
            $display("FAIL R9 stage_q actual %b expected a legal pattern for mode %0d",
                     stage_q, exp_mode);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic m);
        @(negedge clk);
        if (have_exp) check_now();
        rst = r; en = e; mode = m;
        if (r) begin
            exp_q = seed_of(m); exp_mode = m; exp_tag = m ? "R2" : "R1";
        end else if (m != exp_mode) begin
            exp_q = seed_of(m); exp_mode = m; exp_tag = "R6";
        end else if (e) begin
            exp_q = advance(exp_q, m); exp_tag = m ? "R4" : "R3";
        end else begin
            exp_tag = "R5";
        end
        have_exp = 1'b1;
    endtask

    initial begin
        #(CLK_PER * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic sm;
        logic se;
        void'($urandom(32'd20240611));
        // R1: ring seed, then a full ring lap including the wrap (R3)
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < N + 2; i++) step(1'b0, 1'b1, 1'b0);
        // R5: hold with enable low
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
        // R6: switch to twisted ring while disabled
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        // R4: two full twisted laps through all ones and back to zero
        for (int i = 0; i < 4*N + 1; i++) step(1'b0, 1'b1, 1'b1);
        // R6: switch back to ring while enabled, mid sequence
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        // R2: reset in twisted-ring mode from a ring pattern
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        // random mix
        sm = 1'b1;
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 16 == 0) sm = ~sm;
            se = ($urandom % 4) != 0;
            step(($urandom % 64) == 0, se, sm);
        end
        step(1'b0, 1'b0, sm);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule